// File: doc/BRIEF.md
# Indexed-Register I2C Target

This block is an I2C target that lets a bus controller reach a small file of four 16-bit registers through a pointer. A write transfer carries the device address, then a pointer byte, then any number of words. Each word is sent high byte first, and each completed word is committed to the register that the pointer selects. A read transfer needs no pointer byte. It streams the word at the pointer as it stood after the most recent write, high byte first. The block runs from an oversampling system clock. It resynchronises SCL and SDA, finds START, repeated START and STOP, and drives only an open-drain pull-down enable for SDA.

Besides its own address, which is picked from eight values by a 3-bit strap, the block answers the all-zero address. With the write bit set it takes a general call and accepts exactly one payload byte, which it discards. With the read bit set it treats the transfer as a START byte and returns the pointed-to word. A high-speed controller code is left without acknowledge and raises a mode flag until the next STOP. SCL held low for too long drops the bus engine back to idle. The register file sits outside the block. The block gives it a register address, write data, a one-cycle write strobe, and a read strobe that the alert logic can use to clear itself.

Top module: `i2c_index_target`

## Requirements
- R1: The block acknowledges its address byte only when the 7-bit address equals 0x44 plus `addrSel` (giving 0x44 to 0x4B) or equals 0x00. Any other address is left unacknowledged and the rest of the transfer is ignored.
- R2: In a write transfer every byte is acknowledged. The byte after the address loads the pointer from its bits 1:0 only; bits 7:2 are discarded. Each following pair of bytes (high byte, then low byte) produces exactly one `regWrEn` pulse, with `regAddr` equal to the pointer and `regWrData` equal to {high byte, low byte}.
- R3: Register 0 is read-only. Word bytes sent while the pointer is 0 are still acknowledged, but `regWrEn` never pulses.
- R4: A read transfer returns bit 15 first, high byte then low byte, of the register selected by the pointer left by the latest write transfer. A second read with no new pointer write returns the same register.
- R5: When the controller leaves a read byte unacknowledged, the block stops driving SDA and does not drive it again until a new START.
- R6: `regRdStrobe` is a single-cycle pulse. It fires once per read transfer, when the first data byte has been shifted out.
- R7: For address 0x00 with R/W=0, the block acknowledges the address and the next byte, changes neither the pointer nor any register, and leaves every later byte unacknowledged.
- R8: For address 0x00 with R/W=1, the block acknowledges and returns the word at the current pointer. After reset the pointer is 0.
- R9: A first byte of the form 0000_1xxx is left unacknowledged and sets `hsMode`. `hsMode` survives a repeated START and clears on STOP.
- R10: If SCL stays low for TIMEOUT_CYCLES system clocks, the block releases SDA and ignores bus activity until the next START.
- R11: START is an SDA fall and STOP an SDA rise, each seen while SCL is high in both the current and the previous synchronised sample. An SDA change that lands on the same sample as an SCL rise is taken as a data bit.
- R12: After reset, `sdaOe`, `hsMode`, `regWrEn` and `regRdStrobe` are 0 and `regAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| addrSel | input | 3 | Strap code; the device address is 0x44 + addrSel |
| sdaOe | output | 1 | 1 pulls SDA low (open drain) |
| hsMode | output | 1 | High-speed code seen, held until STOP |
| regAddr | output | clog2(NUM_REGS) | Register selected by the pointer |
| regWrData | output | 16 | Word to be written |
| regWrEn | output | 1 | One-cycle write strobe |
| regRdData | input | 16 | Word read from the register at regAddr |
| regRdStrobe | output | 1 | One-cycle pulse after the first byte of a read |

## Verification
The case examined closely is a data-bit change on SDA that reaches the synchroniser in the same system cycle as the SCL rise. In that cycle the bit sampler and the START/STOP detector both see an SDA edge with SCL high. The bench drives every bit of one full write transfer this way, moving SDA and raising SCL on the same clock. The result is judged by the acknowledge on every byte, by the pointer and word arriving on the write strobe unchanged, and by the transfer not being cut short by a false condition.

// File: rtl/i2c_idx_pkg.sv
package i2c_idx_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  // upper five bits of a high-speed controller code
  localparam logic [4:0] HS_CODE_TOP = 5'b00001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKOUT,
    ST_TX,
    ST_ACKIN,
    ST_IGNORE
  } busState_t;

  typedef enum logic [1:0] {
    XF_WRITE,
    XF_READ,
    XF_GCALL
  } xfer_t;

  typedef struct packed {
    logic rxShift;
    logic rxBit;
    logic loadIndex;
    logic holdMsb;
    logic commitWord;
    logic loadTxMsb;
    logic loadTxLsb;
    logic txShift;
  } dpCtl_t;

endpackage

// File: rtl/i2c_idx_ctrl.sv
module i2c_idx_ctrl
  import i2c_idx_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int TIMEOUT_CYCLES = 3_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [6:0] devAddr,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpCtl_t     ctl,
  output logic       sdaOe,
  output logic       hsMode,
  output logic       rdStrobe
);

  localparam int TO_W = $clog2(TIMEOUT_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet, toFire;
  logic [TO_W-1:0] lowCnt;

  busState_t state, stateN;
  xfer_t     xfer, xferN;
  logic [3:0] bitCnt, bitCntN;
  logic [1:0] byteIdx, byteIdxN;
  logic nackSeen, nackN, firstRd, firstRdN, lsbNext, lsbNextN, hsN, rdStbN;
  logic [6:0] addrField;
  logic rwBit;

  // input synchronisers, idle-high reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  // SCL-low watchdog, saturating; fires once per low stretch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            lowCnt <= '0;
    else if (sclS)                         lowCnt <= '0;
    else if (lowCnt != TO_W'(TIMEOUT_CYCLES)) lowCnt <= lowCnt + 1'b1;
  end
  assign toFire = ~sclS && (lowCnt == TO_W'(TIMEOUT_CYCLES - 1));

  assign addrField = rxByte[7:1];
  assign rwBit     = rxByte[0];

  always_comb begin
    ctl       = '0;
    ctl.rxBit = sdaS;
    stateN    = state;
    xferN     = xfer;
    bitCntN   = bitCnt;
    byteIdxN  = byteIdx;
    nackN     = nackSeen;
    firstRdN  = firstRd;
    lsbNextN  = lsbNext;
    hsN       = hsMode;
    rdStbN    = 1'b0;
    if (startDet) begin
      stateN   = ST_RX;
      bitCntN  = '0;
      byteIdxN = '0;
      firstRdN = 1'b0;
    end else if (stopDet) begin
      stateN = ST_IDLE;
      hsN    = 1'b0;
    end else if (toFire) begin
      stateN = ST_IDLE;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise && bitCnt != 4'd8) begin
            ctl.rxShift = 1'b1;
            bitCntN     = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            stateN = ST_ACKOUT;
            case (byteIdx)
              2'd0: begin
                byteIdxN = 2'd1;
                if (addrField == devAddr) begin
                  xferN    = rwBit ? XF_READ : XF_WRITE;
                  firstRdN = rwBit;
                end else if (addrField == 7'd0) begin
                  xferN    = rwBit ? XF_READ : XF_GCALL;
                  firstRdN = rwBit;
                end else begin
                  stateN = ST_IGNORE;
                  if (rxByte[7:3] == HS_CODE_TOP) hsN = 1'b1;
                end
              end
              2'd1: begin
                byteIdxN = 2'd2;
                if (xfer == XF_WRITE) ctl.loadIndex = 1'b1;
              end
              2'd2: begin
                if (xfer == XF_WRITE) begin
                  ctl.holdMsb = 1'b1;
                  byteIdxN    = 2'd3;
                end else begin
                  stateN = ST_IGNORE;
                end
              end
              default: begin
                ctl.commitWord = 1'b1;
                byteIdxN       = 2'd2;
              end
            endcase
          end
        end
        ST_ACKOUT: begin
          if (sclFall) begin
            bitCntN = '0;
            if (xfer == XF_READ) begin
              ctl.loadTxMsb = 1'b1;
              lsbNextN      = 1'b1;
              stateN        = ST_TX;
            end else begin
              stateN = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclRise && bitCnt != 4'd8) begin
            bitCntN = bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              stateN = ST_ACKIN;
              nackN  = 1'b1;
              if (firstRd) begin
                rdStbN   = 1'b1;
                firstRdN = 1'b0;
              end
            end else if (bitCnt != 4'd0) begin
              ctl.txShift = 1'b1;
            end
          end
        end
        ST_ACKIN: begin
          if (sclRise) begin
            nackN = sdaS;
          end else if (sclFall) begin
            if (!nackSeen) begin
              stateN  = ST_TX;
              bitCntN = '0;
              if (lsbNext) ctl.loadTxLsb = 1'b1;
              else         ctl.loadTxMsb = 1'b1;
              lsbNextN = ~lsbNext;
            end else begin
              stateN = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      xfer     <= XF_WRITE;
      bitCnt   <= '0;
      byteIdx  <= '0;
      nackSeen <= 1'b1;
      firstRd  <= 1'b0;
      lsbNext  <= 1'b0;
      hsMode   <= 1'b0;
      rdStrobe <= 1'b0;
    end else begin
      state    <= stateN;
      xfer     <= xferN;
      bitCnt   <= bitCntN;
      byteIdx  <= byteIdxN;
      nackSeen <= nackN;
      firstRd  <= firstRdN;
      lsbNext  <= lsbNextN;
      hsMode   <= hsN;
      rdStrobe <= rdStbN;
    end
  end

  assign sdaOe = (state == ST_ACKOUT) | ((state == ST_TX) & ~txBit);

  // R5 / R10: idle or ignoring never pulls the line
  p_quiet_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_IGNORE) |-> !sdaOe);

  // R6: read strobe is a single-cycle pulse
  p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdStrobe |=> !rdStrobe);

  // R9: STOP always drops the high-speed flag
  p_hs_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stopDet |=> !hsMode);

  // R10: watchdog expiry returns the engine to idle
  p_timeout_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (toFire && !startDet && !stopDet) |=> (state == ST_IDLE));

  // R11: the block moves SDA only while SCL is low, so it never forms a condition
  p_sda_move_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdaOe) |-> !sclS);

endmodule

// File: rtl/i2c_idx_data.sv
module i2c_idx_data
  import i2c_idx_pkg::*;
#(
  parameter int               NUM_REGS       = 4,
  parameter logic [NUM_REGS-1:0] READ_ONLY_MASK = 4'b0001
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  dpCtl_t                      ctl,
  input  logic [WORD_W-1:0]           rdData,
  output logic [BYTE_W-1:0]           rxByte,
  output logic                        txBit,
  output logic [$clog2(NUM_REGS)-1:0] regAddr,
  output logic [WORD_W-1:0]           wrData,
  output logic                        wrEn
);

  localparam int IDX_W = $clog2(NUM_REGS);

  logic [BYTE_W-1:0] rxSh, msbHold, txSh;
  logic [IDX_W-1:0]  index;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxSh    <= '0;
      msbHold <= '0;
      txSh    <= '1;
      index   <= '0;
      wrData  <= '0;
      wrEn    <= 1'b0;
    end else begin
      if (ctl.rxShift)   rxSh    <= {rxSh[BYTE_W-2:0], ctl.rxBit};
      if (ctl.loadIndex) index   <= rxSh[IDX_W-1:0];
      if (ctl.holdMsb)   msbHold <= rxSh;
      wrEn <= 1'b0;
      if (ctl.commitWord) begin
        wrEn   <= ~READ_ONLY_MASK[index];
        wrData <= {msbHold, rxSh};
      end
      if (ctl.loadTxMsb)      txSh <= rdData[WORD_W-1:BYTE_W];
      else if (ctl.loadTxLsb) txSh <= rdData[BYTE_W-1:0];
      else if (ctl.txShift)   txSh <= {txSh[BYTE_W-2:0], 1'b1};
    end
  end

  assign rxByte  = rxSh;
  assign txBit   = txSh[BYTE_W-1];
  assign regAddr = index;

  // R3: no strobe may reach a read-only entry
  p_ro_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> !READ_ONLY_MASK[regAddr]);

  // R2: a word commit is a single-cycle strobe
  p_wr_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> !wrEn);

  // R2: pointer is stable while a word is being committed
  p_idx_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> $stable(regAddr));

endmodule

// File: rtl/i2c_index_target.sv
module i2c_index_target
  import i2c_idx_pkg::*;
#(
  parameter logic [6:0]          BASE_ADDR      = 7'h44,
  parameter int                  TIMEOUT_CYCLES = 3_000_000,
  parameter int                  SYNC_STAGES    = 2,
  parameter int                  NUM_REGS       = 4,
  parameter logic [NUM_REGS-1:0] READ_ONLY_MASK = 4'b0001
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sclIn,
  input  logic                        sdaIn,
  input  logic [2:0]                  addrSel,
  output logic                        sdaOe,
  output logic                        hsMode,
  output logic [$clog2(NUM_REGS)-1:0] regAddr,
  output logic [15:0]                 regWrData,
  output logic                        regWrEn,
  input  logic [15:0]                 regRdData,
  output logic                        regRdStrobe
);

  dpCtl_t     ctl;
  logic [7:0] rxByte;
  logic       txBit;
  logic [6:0] devAddr;

  assign devAddr = BASE_ADDR + 7'(addrSel);

  i2c_idx_ctrl #(
    .SYNC_STAGES   (SYNC_STAGES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) uCtrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .devAddr (devAddr),
    .rxByte  (rxByte),
    .txBit   (txBit),
    .ctl     (ctl),
    .sdaOe   (sdaOe),
    .hsMode  (hsMode),
    .rdStrobe(regRdStrobe)
  );

  i2c_idx_data #(
    .NUM_REGS      (NUM_REGS),
    .READ_ONLY_MASK(READ_ONLY_MASK)
  ) uData (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .rdData (regRdData),
    .rxByte (rxByte),
    .txBit  (txBit),
    .regAddr(regAddr),
    .wrData (regWrData),
    .wrEn   (regWrEn)
  );

endmodule

// File: tb/i2c_index_target_test.sv
module i2c_index_target_test;

  localparam int H  = 20;
  localparam int TO = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [2:0] addrSel = 3'd5;
  logic sdaOe, hsMode, regWrEn, regRdStrobe;
  logic [1:0] regAddr;
  logic [15:0] regWrData, regRdData;
  logic sdaLine;

  int nChecks = 0, nFails = 0, nStrobes = 0;
  bit done = 1'b0;
  logic [17:0] wq[$];
  logic [15:0] regs [4];

  always #5 clk = ~clk;

  assign sdaLine   = sdaM & ~sdaOe;
  assign regRdData = regs[regAddr];

  i2c_index_target #(.TIMEOUT_CYCLES(TO)) uut (
    .clk(clk), .rst_n(rst_n), .sclIn(sclM), .sdaIn(sdaLine), .addrSel(addrSel),
    .sdaOe(sdaOe), .hsMode(hsMode), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData), .regRdStrobe(regRdStrobe));

  // external register file model
  always @(posedge clk) if (regWrEn) regs[regAddr] <= regWrData;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference comparison of the write strobe, every clock
  always @(negedge clk) begin
    if (rst_n && regWrEn) begin
      if (wq.size() == 0) chk(1'b0, "R2/R3 unexpected write", {regAddr, regWrData}, 0);
      else begin
        logic [17:0] e;
        e = wq.pop_front();
        chk({regAddr, regWrData} == e, "R2 write word", {regAddr, regWrData}, e);
      end
    end
    if (rst_n && regRdStrobe) nStrobes++;
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitN(H);
    sclM = 1'b1; waitN(H);
    sdaM = 1'b0; waitN(H);
    sclM = 1'b0; waitN(H);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitN(H);
    sclM = 1'b1; waitN(H);
    sdaM = 1'b1; waitN(H);
  endtask

  task automatic sendBits8(input logic [7:0] b, input bit same);
    for (int i = 7; i >= 0; i--) begin
      if (same) begin
        waitN(H);
        sdaM = b[i]; sclM = 1'b1;
      end else begin
        sdaM = b[i]; waitN(H);
        sclM = 1'b1;
      end
      waitN(H);
      sclM = 1'b0; waitN(2);
    end
  endtask

  task automatic ackClock(output bit ack);
    sdaM = 1'b1; waitN(H);
    sclM = 1'b1; waitN(H);
    ack = ~sdaLine;
    sclM = 1'b0; waitN(H);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit same, output bit ack);
    sendBits8(b, same);
    ackClock(ack);
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] v);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitN(H);
      sclM = 1'b1; waitN(H);
      v[i] = sdaLine;
      sclM = 1'b0;
    end
    waitN(2);
    sdaM = ackIt ? 1'b0 : 1'b1; waitN(H);
    sclM = 1'b1; waitN(H);
    sclM = 1'b0; waitN(2);
    sdaM = 1'b1;
  endtask

  task automatic readWord(input logic [7:0] addrByte, input string tag, input logic [15:0] exp);
    bit a;
    logic [7:0] hi, lo;
    busStart();
    sendByte(addrByte, 1'b0, a);
    chk(a, {tag, " address ack"}, a, 1);
    recvByte(1'b1, hi);
    recvByte(1'b0, lo);
    busStop();
    chk({hi, lo} == exp, {tag, " word"}, {hi, lo}, exp);
  endtask

  initial begin
    bit a;
    logic [7:0] v;
    regs[0] = 16'h0C80; regs[1] = 16'h60A0; regs[2] = 16'h2580; regs[3] = 16'h2800;
    waitN(5);
    // R12: reset state
    chk(sdaOe == 0 && hsMode == 0 && regWrEn == 0 && regRdStrobe == 0, "R12 outputs", {sdaOe, hsMode, regWrEn, regRdStrobe}, 0);
    chk(regAddr == 0, "R12 pointer", regAddr, 0);
    rst_n = 1'b1;
    waitN(5);

    // R8: START byte right after reset returns register 0
    readWord(8'h01, "R8 start byte", 16'h0C80);
    chk(nStrobes == 1, "R6 one strobe per read", nStrobes, 1);

    // R1: foreign address gets no ACK
    busStart();
    sendByte(8'h88, 1'b0, a);
    chk(!a, "R1 foreign address nack", a, 0);
    busStop();

    // R2: write pointer 0x06 (bits 7:2 dropped -> register 2), two words
    wq.push_back({2'd2, 16'h1234});
    wq.push_back({2'd2, 16'hABCD});
    busStart();
    sendByte(8'h92, 1'b0, a); chk(a, "R1 own address ack", a, 1);
    sendByte(8'h06, 1'b0, a); chk(a, "R2 pointer ack", a, 1);
    sendByte(8'h12, 1'b0, a); chk(a, "R2 msb ack", a, 1);
    sendByte(8'h34, 1'b0, a); chk(a, "R2 lsb ack", a, 1);
    sendByte(8'hAB, 1'b0, a); sendByte(8'hCD, 1'b0, a); chk(a, "R2 second word ack", a, 1);
    busStop();
    chk(wq.size() == 0, "R2 all words committed", wq.size(), 0);

    // R4: read twice from the same pointer
    readWord(8'h93, "R4 read", 16'hABCD);
    readWord(8'h93, "R4 repeat read", 16'hABCD);

    // R3: register 0 writes acknowledged but dropped
    busStart();
    sendByte(8'h92, 1'b0, a);
    sendByte(8'h00, 1'b0, a);
    sendByte(8'hFF, 1'b0, a); chk(a, "R3 msb ack", a, 1);
    sendByte(8'hFF, 1'b0, a); chk(a, "R3 lsb ack", a, 1);
    busStop();
    readWord(8'h93, "R3 register 0 unchanged", 16'h0C80);

    // R7: general call leaves pointer alone
    busStart();
    sendByte(8'h92, 1'b0, a);
    sendByte(8'h01, 1'b0, a);
    busStop();
    busStart();
    sendByte(8'h00, 1'b0, a); chk(a, "R7 general call ack", a, 1);
    sendByte(8'h06, 1'b0, a); chk(a, "R7 second byte ack", a, 1);
    sendByte(8'h55, 1'b0, a); chk(!a, "R7 third byte nack", a, 0);
    busStop();
    readWord(8'h93, "R7 pointer unchanged", 16'h60A0);

    // R9: high-speed code
    busStart();
    sendByte(8'h08, 1'b0, a);
    chk(!a, "R9 code nack", a, 0);
    chk(hsMode == 1, "R9 mode set", hsMode, 1);
    busStart();
    sendByte(8'h93, 1'b0, a); chk(a, "R9 address after code", a, 1);
    chk(hsMode == 1, "R9 mode held over repeated START", hsMode, 1);
    recvByte(1'b0, v);
    busStop();
    chk(hsMode == 0, "R9 mode cleared by STOP", hsMode, 0);

    // R5: NACK after first byte, then extra clocks see a released line
    busStart();
    sendByte(8'h93, 1'b0, a);
    recvByte(1'b0, v);
    chk(v == 8'h60, "R5 msb before nack", v, 8'h60);
    recvByte(1'b0, v);
    chk(v == 8'hFF, "R5 line released after nack", v, 8'hFF);
    busStop();
    chk(nStrobes == 7, "R6 strobe count", nStrobes, 7);

    // R10: SCL held low while acknowledging
    busStart();
    sendBits8(8'h92, 1'b0);
    waitN(10);
    chk(sdaOe == 1, "R10 ack driven before timeout", sdaOe, 1);
    waitN(TO + 100);
    chk(sdaOe == 0, "R10 released after timeout", sdaOe, 0);
    sdaM = 1'b1; waitN(H);
    sendByte(8'h92, 1'b0, a);
    chk(!a, "R10 ignored until START", a, 0);
    busStop();
    wq.push_back({2'd1, 16'h0A0B});
    busStart();
    sendByte(8'h92, 1'b0, a); chk(a, "R10 recovers on START", a, 1);
    sendByte(8'h01, 1'b0, a); sendByte(8'h0A, 1'b0, a); sendByte(8'h0B, 1'b0, a);
    busStop();

    // R11: SDA moves on the same clock as the SCL rise
    wq.push_back({2'd3, 16'h0FF0});
    busStart();
    sendByte(8'h92, 1'b1, a); chk(a, "R11 address ack", a, 1);
    sendByte(8'h03, 1'b1, a); chk(a, "R11 pointer ack", a, 1);
    sendByte(8'h0F, 1'b1, a); chk(a, "R11 msb ack", a, 1);
    sendByte(8'hF0, 1'b1, a); chk(a, "R11 lsb ack", a, 1);
    busStop();
    chk(wq.size() == 0, "R11 word committed", wq.size(), 0);

    waitN(20);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule